// File: doc/BRIEF.md
# Gated Integer Clock Divider

This block derives a slower clock from an input clock by a fixed integer ratio from 1 to 8, chosen at elaboration. The output starts with a rising edge on the first input edge after the clear is let go, whatever the ratio. As a result, several copies running at different ratios from one clock and one clear stay phase-aligned. Even ratios give a 50% duty cycle. Odd ratios keep the output high for one input cycle less than they keep it low.

An enable input pauses the divider. While it is inactive the output keeps its level and the period counter keeps its count. When the enable becomes active again, the period carries on from the held count. The clear forces the output low at once and holds it there. The clear is released on an input clock edge. An optional three-stage synchronizer can sit in the enable path, and each of the two control inputs can be given either active level by a parameter.

For ratios above 1 the divider is a three-state machine. CLEAR is the state held by the clear. The transition RELEASE goes from CLEAR to HIGH on the first enabled edge. FALL goes from HIGH to LOW when the count reaches the high-phase length. WRAP goes from LOW to HIGH after the last count of the period. FREEZE is the self-loop taken by any state on an edge where the enable is inactive. For ratio 1 the output is the input clock, passed through a gate that is latched while the input clock is low.

Top module: `clkdiv_gated`

## Requirements
- R1: Parameter DIVIDE (1 to 8, default 1) sets the ratio. With the enable held active, the output repeats every DIVIDE input cycles.
- R2: While the clear is active the output is 0. If the output is high when the clear is asserted, it goes low without waiting for a clock edge.
- R3: The output rises on the first input rising edge after the clear is released, if the enable is active at that edge. This holds for every ratio, so outputs of different ratios rise together.
- R4: For an even ratio N, the output is high for N/2 enabled input cycles and then low for N/2.
- R5: For an odd ratio N, the output is high for (N-1)/2 enabled input cycles and then low for (N+1)/2.
- R6: On an input edge where the enable is inactive, the output keeps its level and the period count does not advance.
- R7: When the enable returns, the period continues from the held count. For example, at ratio 8, with the enable dropped two cycles after a rising edge, the output falls two enabled edges after the enable returns.
- R8: At ratio 1 the output equals the input clock while enabled. It stays low while disabled and never emits a shortened pulse.
- R9: With HARD_SYNC=1, an enable level applied before input edge j first takes effect at edge j+3, after three synchronizer stages.
- R10: CLR_INVERT=1 makes the clear active-low, and ENA_INVERT=1 makes the enable active-low. The clock input and output are never inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| clr | input | 1 | Clear: asserts asynchronously, releases on a clock edge; active level set by CLR_INVERT |
| ena | input | 1 | Enable; active level set by ENA_INVERT |
| clk_out | output | 1 | Divided clock |

## Verification
The bench runs all eight ratios side by side from one clock, clear and enable. After each input edge it compares every output with a count of enabled edges taken modulo the ratio.

- Release alignment: a divider that needed an extra edge to leave clear would rise late and fall out of step with the other ratios.
- Odd-ratio duty cycle: an off-by-one high-phase length would show up as 4/3 instead of 3/4 at ratio 7.
- Irregular enable gaps: a counter that kept running or restarted while disabled would shift every later edge.
- Clear raised in the middle of a high phase: a clear that waited for an edge would leave a high output standing.
- Inverted-polarity, hard-synchronized copy: an instance that acted on the enable one edge early or late would be caught.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Output level is bit 0 of the state code, so the clock comes straight from a flop.
    typedef enum logic [1:0] {
        ST_CLEAR = 2'b00,
        ST_HIGH  = 2'b01,
        ST_LOW   = 2'b10
    } div_state_e;

    localparam int DIV_MAX     = 8;
    localparam int SYNC_STAGES = 3;

endpackage

// File: rtl/clkdiv_ctl.sv
module clkdiv_ctl
    import clkdiv_pkg::*;
#(
    parameter bit HARD_SYNC  = 1'b0,
    parameter bit CLR_INVERT = 1'b0,
    parameter bit ENA_INVERT = 1'b0
) (
    input  logic clk_in,
    input  logic clr_raw,
    input  logic ena_raw,
    output logic clr_act,
    output logic ena_s
);

    logic ena_lvl;

    // Polarity selection on the control pins (R10)
    assign clr_act = clr_raw ^ CLR_INVERT;
    assign ena_lvl = ena_raw ^ ENA_INVERT;

    generate
        if (HARD_SYNC) begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;

            // Free-running chain, not cleared, so a held enable survives a clear (R9)
            always_ff @(posedge clk_in) begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], ena_lvl};
            end

            assign ena_s = sync_q[SYNC_STAGES-1];
        end else begin : g_direct
            assign ena_s = ena_lvl;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_pass1.sv
module clkdiv_pass1 (
    input  logic clk_in,
    input  logic clr_act,
    input  logic ena_s,
    output logic clk_out
);

    logic gate_q;

    // Gate may only change while the clock is low: no runt pulse (R8)
    always_latch begin
        if (!clk_in) begin
            gate_q = ena_s & ~clr_act;
        end
    end

    // Clear overrides the latched gate at once (R2)
    assign clk_out = clk_in & gate_q & ~clr_act;

endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
#(
    parameter int DIVIDE = 2
) (
    input  logic clk_in,
    input  logic clr_act,
    input  logic ena_s,
    output logic clk_out
);

    localparam int CW = (DIVIDE > 2) ? $clog2(DIVIDE) : 1;
    localparam int HI = DIVIDE / 2;
    localparam logic [CW-1:0] HI_C   = CW'(HI);
    localparam logic [CW-1:0] LAST_C = CW'(DIVIDE - 1);

    div_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d, cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;

    // Next-state logic: RELEASE, FALL, WRAP; FREEZE when the enable is inactive
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (ena_s) begin
            unique case (state_q)
                ST_CLEAR: begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                end
                ST_HIGH: begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == HI_C) begin
                        state_d = ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (cnt_q == LAST_C) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                default: begin
                    state_d = ST_CLEAR;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register: asynchronous clear, release on the clock edge
    always_ff @(posedge clk_in or posedge clr_act) begin
        if (clr_act) begin
            state_q <= ST_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output process: clock taken from the state flop bit
    always_comb begin
        clk_out = state_q[0];
    end

    AST_CLR_HOLDS: assert property (@(posedge clk_in)
        clr_act |-> (state_q == ST_CLEAR && !clk_out)); // R2

    AST_RELEASE_HIGH: assert property (@(posedge clk_in) disable iff (clr_act)
        (state_q == ST_CLEAR && ena_s) |=> (state_q == ST_HIGH && cnt_q == '0)); // R3

    AST_HIGH_BOUND: assert property (@(posedge clk_in) disable iff (clr_act)
        (state_q == ST_HIGH) |-> (cnt_q < HI_C)); // R4

    AST_LOW_BOUND: assert property (@(posedge clk_in) disable iff (clr_act)
        (state_q == ST_LOW) |-> (cnt_q >= HI_C)); // R5

    AST_FREEZE: assert property (@(posedge clk_in) disable iff (clr_act)
        !ena_s |=> ($stable(state_q) && $stable(cnt_q))); // R6

    AST_RESUME_STEP: assert property (@(posedge clk_in) disable iff (clr_act)
        (ena_s && state_q != ST_CLEAR && cnt_q != LAST_C)
            |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R7

endmodule

// File: rtl/clkdiv_gated.sv
module clkdiv_gated
    import clkdiv_pkg::*;
#(
    parameter int DIVIDE     = 1,
    parameter bit HARD_SYNC  = 1'b0,
    parameter bit CLR_INVERT = 1'b0,
    parameter bit ENA_INVERT = 1'b0
) (
    input  logic clk_in,
    input  logic clr,
    input  logic ena,
    output logic clk_out
);

    logic clr_act;
    logic ena_s;

    clkdiv_ctl #(
        .HARD_SYNC  (HARD_SYNC),
        .CLR_INVERT (CLR_INVERT),
        .ENA_INVERT (ENA_INVERT)
    ) u_ctl (
        .clk_in  (clk_in),
        .clr_raw (clr),
        .ena_raw (ena),
        .clr_act (clr_act),
        .ena_s   (ena_s)
    );

    // Ratio 1 uses the latched gate; 2..DIV_MAX use the state machine (R1)
    generate
        if (DIVIDE <= 1) begin : g_pass
            clkdiv_pass1 u_pass (
                .clk_in  (clk_in),
                .clr_act (clr_act),
                .ena_s   (ena_s),
                .clk_out (clk_out)
            );
        end else begin : g_div
            clkdiv_fsm #(
                .DIVIDE ((DIVIDE > DIV_MAX) ? DIV_MAX : DIVIDE)
            ) u_fsm (
                .clk_in  (clk_in),
                .clr_act (clr_act),
                .ena_s   (ena_s),
                .clk_out (clk_out)
            );
        end
    endgenerate

endmodule

// File: tb/sim_clkdiv_gated.sv
`timescale 1ns/1ps
module sim_clkdiv_gated;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       en  = 1'b1;
    logic       hs_en_n = 1'b0;
    logic       hs_clr_n;
    logic [8:1] outs;
    logic       hs_out;

    int nchk  = 0;
    int nfail = 0;
    int m     = 0;     // enabled edges since release, shared enable
    int hm    = 0;     // same for the hard-synchronized copy
    logic [2:0] pipe = 3'b000;
    logic d1 = 1'b0;   // expected ratio-1 level in the high phase

    always #5 clk = ~clk;
    assign hs_clr_n = ~clr;

    generate
        for (genvar n = 1; n <= 8; n++) begin : g_div
            clkdiv_gated #(.DIVIDE(n)) u0 (
                .clk_in (clk),
                .clr    (clr),
                .ena    (en),
                .clk_out(outs[n])
            );
        end
    endgenerate

    // Ratio 4, hard sync, both controls active-low (R9, R10)
    clkdiv_gated #(.DIVIDE(4), .HARD_SYNC(1'b1), .CLR_INVERT(1'b1), .ENA_INVERT(1'b1)) u1 (
        .clk_in (clk),
        .clr    (hs_clr_n),
        .ena    (hs_en_n),
        .clk_out(hs_out)
    );

    task automatic chk(input string tag, input int n, input logic got, input logic exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s div=%0d got=%b expected=%b", tag, n, got, exp);
        end
    endtask

    function automatic logic exp_out(input int n, input int cnt);
        if (cnt < 1) return 1'b0;
        return (((cnt - 1) % n) < (n / 2));
    endfunction

    function automatic string run_tag(input int n);
        if (n == 1) return "R8";
        return (n % 2 == 1) ? "R1 R5" : "R1 R4";
    endfunction

    // One input cycle: drive at the falling edge, model at the rising edge, check 2 ns later
    task automatic step(input logic e, input logic c, input logic he, input string ph);
        logic eff;
        @(negedge clk);
        en      = e;
        clr     = c;
        hs_en_n = ~he;
        @(posedge clk);
        if (c) m = 0; else if (e) m++;
        d1  = e & ~c;
        eff = pipe[2];
        pipe = {pipe[1:0], he};
        if (c) hm = 0; else if (eff) hm++;
        #2;
        for (int n = 1; n <= 8; n++) begin
            string t;
            t = (ph == "") ? run_tag(n) : ph;
            chk(t, n, outs[n], (n == 1) ? d1 : exp_out(n, m));
        end
        chk("R9 R10", 4, hs_out, exp_out(4, hm));
    endtask

    task automatic async_clear();
        #1;
        clr = 1'b1;
        #1;
        for (int n = 1; n <= 8; n++) chk("R2", n, outs[n], 1'b0);
        chk("R2 R10", 4, hs_out, 1'b0);
        m  = 0;
        hm = 0;
        d1 = 1'b0;
    endtask

    initial begin
        #3;
        for (int n = 1; n <= 8; n++) chk("R2", n, outs[n], 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b1, "R2");
        // Release: every ratio rises together
        step(1'b1, 1'b0, 1'b1, "R3");
        for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 1'b1, "");
        // Irregular enable gaps at shifting phases
        for (int k = 0; k < 60; k++) begin
            logic e;
            e = ((k * k + 3 * k) % 7) > 2;
            step(e, 1'b0, ((k / 5) % 2) == 0, "R6 R7");
        end
        // Ratio-8 example: drop the enable two edges after a rise, then resume
        step(1'b1, 1'b1, 1'b1, "R2");
        step(1'b1, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b1, "R7");
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b1, "R6");
        for (int k = 0; k < 12; k++) step(1'b1, 1'b0, 1'b1, "R7");
        // Clear raised during a high phase, then a second aligned release
        step(1'b1, 1'b1, 1'b1, "R2");
        step(1'b1, 1'b0, 1'b1, "R3");
        async_clear();
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, "R2");
        step(1'b1, 1'b0, 1'b1, "R3");
        for (int k = 0; k < 24; k++) step(1'b1, 1'b0, 1'b1, "");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #50000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule